// File: doc/BRIEF.md
# Recovered Byte Clock Generator

This block turns a serial bit stream into 10-bit characters and produces a byte-rate recovered clock for them. It is clocked by the system clock and advances only on a reference bit-time tick. On each tick it shifts in one sampled bit. It also takes an early/late indication from an upstream phase tracker, which shows whether the far-end transmitter is pulling ahead of the local reference or falling behind it.

Each byte period normally lasts ten ticks, and a new character is available at the rising edge of the recovered clock. A transmitter that runs fast or slow makes the bit phase drift. The block counts that drift in a small signed accumulator. When the drift reaches two bit-times, the block schedules one adjusted period: a short period of eight ticks, or a long period of twelve ticks. This takes up the offset without a clock recovery loop. At an offset of N ppm, adjusted periods appear about once every 2e5/N characters, which is roughly every 800 characters at the 250 ppm limit.

The character output is a stream with a valid strobe and no ready input. A byte arrives whether or not a consumer is waiting, so the block cannot accept back-pressure. The consumer must take each character within the shortest period, which is eight ticks. The character stays on the data pins until the next strobe.

Top module: `recovered_byte_clk`

## Requirements
- R1: A synchronous reset clears the data output, the strobe, the recovered clock, the bit counter, the drift accumulator and any scheduled adjustment. The first strobe follows the tenth tick after reset is released, and the recovered clock stays low until then.
- R2: With no adjustment scheduled, a period lasts 10 ticks. `char_valid` is high for exactly one system clock after the final tick of each period, and it coincides with a rising edge of `rclk`.
- R3: The character is made of the 10 most recent bits. The bit received first sits at bit 0 and the bit received last sits at bit 9.
- R4: On a tick, early alone adds 1 to the drift and late alone subtracts 1. Both or neither leaves the drift unchanged. A drift of +2 schedules a short period, a drift of -2 schedules a long period, and in both cases the drift returns to 0.
- R5: A scheduled short adjustment makes the next period that starts last 8 ticks. The period that follows is nominal again.
- R6: A scheduled long adjustment makes the next period that starts last 12 ticks.
- R7: `rclk` is high for the first floor(length/2) ticks of every period and low for the rest: 4 ticks of 8, 5 of 10 and 6 of 12.
- R8: `char_data` holds its value from one strobe to the next.
- R9: At most one adjustment is pending at a time. An event that would take the drift to ±2 while an adjustment is pending is dropped, and the drift stays at ±1.
- R10: System clock cycles without a tick change nothing: early, late and the bit input are ignored on those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | Reference bit-time enable, one system clock wide |
| bit_in | input | 1 | Sampled serial bit, taken on a tick |
| early | input | 1 | Phase tracker: transmitter gained one bit-time |
| late | input | 1 | Phase tracker: transmitter lost one bit-time |
| char_data | output | 10 | Assembled character |
| char_valid | output | 1 | One-clock strobe marking a new character |
| rclk | output | 1 | Recovered byte clock waveform |

## Verification
The embedded assertions check on every cycle the following rules:
- a strobe always lands on a rising edge of the recovered clock;
- the character holds between strobes;
- the clock falls only on a tick;
- a wrap selects the period length that matches the pending adjustment;
- a drift limit schedules exactly one adjustment and never a second one;
- cycles without a tick leave the counter state alone.

Whole-period properties can only be shown by the bench scenarios:
- the measured period lengths and duty counts;
- the character contents against a model shift register;
- an early and a late event cancelling each other;
- the drift that is carried over after a dropped event;
- a reset in the middle of a run clearing a scheduled adjustment.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  // Kind of period adjustment waiting for the next byte boundary
  typedef enum logic [1:0] {
    ADJ_NONE  = 2'd0,
    ADJ_SHORT = 2'd1,
    ADJ_LONG  = 2'd2
  } adj_e;
endpackage

// File: rtl/rbc_drift_tracker.sv
module rbc_drift_tracker
  import rbc_pkg::*;
#(
  parameter int DRIFT_LIM = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic early,
  input  logic late,
  input  logic consume,
  output adj_e pend
);
  localparam int DW = $clog2(DRIFT_LIM + 1) + 2;
  localparam logic signed [DW-1:0] ONE     = 1;
  localparam logic signed [DW-1:0] POS_LIM = DRIFT_LIM;
  localparam logic signed [DW-1:0] NEG_LIM = -POS_LIM;
  localparam logic signed [DW-1:0] POS_M1  = POS_LIM - ONE;

  logic signed [DW-1:0] drift, delta, d_next;
  adj_e pend_base;

  always_comb begin
    if (early && !late)      delta = ONE;
    else if (late && !early) delta = -ONE;
    else                     delta = '0;
  end

  assign d_next    = drift + delta;
  assign pend_base = consume ? ADJ_NONE : pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      drift <= '0;
      pend  <= ADJ_NONE;
    end else if (tick) begin
      pend <= pend_base;
      if (d_next == POS_LIM) begin
        if (pend_base == ADJ_NONE) begin
          pend  <= ADJ_SHORT;
          drift <= d_next - POS_LIM;
        end
      end else if (d_next == NEG_LIM) begin
        if (pend_base == ADJ_NONE) begin
          pend  <= ADJ_LONG;
          drift <= d_next - NEG_LIM;
        end
      end else begin
        drift <= d_next;
      end
    end
  end

  // R4
  lim_sched_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && early && !late && drift == POS_M1 && pend == ADJ_NONE)
      |=> (pend == ADJ_SHORT && drift == '0));

  // R9
  single_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && early && !late && drift == POS_M1 && pend != ADJ_NONE && !consume)
      |=> (pend == $past(pend) && drift == $past(drift)));
endmodule

// File: rtl/rbc_period_ctrl.sv
module rbc_period_ctrl
  import rbc_pkg::*;
#(
  parameter int CHAR_W   = 10,
  parameter int ADJ_BITS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  adj_e pend,
  output logic wrap,
  output logic rclk
);
  localparam int LONG_LEN = CHAR_W + ADJ_BITS;
  localparam int CW       = $clog2(LONG_LEN + 1);
  localparam logic [CW-1:0] NOM_L   = CW'(CHAR_W);
  localparam logic [CW-1:0] SHORT_L = CW'(CHAR_W - ADJ_BITS);
  localparam logic [CW-1:0] LONG_L  = CW'(LONG_LEN);

  logic [CW-1:0] cnt, len, len_sel, cnt_inc, half;

  assign half    = len >> 1;
  assign cnt_inc = cnt + 1'b1;
  assign wrap    = tick && (cnt_inc == len);

  always_comb begin
    case (pend)
      ADJ_SHORT: len_sel = SHORT_L;
      ADJ_LONG:  len_sel = LONG_L;
      default:   len_sel = NOM_L;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      len  <= NOM_L;
      rclk <= 1'b0;
    end else if (tick) begin
      if (wrap) begin
        cnt  <= '0;
        len  <= len_sel;
        rclk <= 1'b1;
      end else begin
        cnt <= cnt_inc;
        if (cnt_inc == half) rclk <= 1'b0;
      end
    end
  end

  // R2
  nom_len_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap && pend == ADJ_NONE) |=> (len == NOM_L));

  // R5
  short_len_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap && pend == ADJ_SHORT) |=> (len == SHORT_L));

  // R6
  long_len_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap && pend == ADJ_LONG) |=> (len == LONG_L));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(cnt) && $stable(len) && $stable(rclk)));
endmodule

// File: rtl/rbc_char_shifter.sv
module rbc_char_shifter #(
  parameter int CHAR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bit_in,
  input  logic              wrap,
  output logic [CHAR_W-1:0] char_data,
  output logic              char_valid
);
  logic [CHAR_W-1:0] shreg, shnext;

  // Newest bit enters at the top, so the oldest ends at bit 0
  assign shnext = {bit_in, shreg[CHAR_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg      <= '0;
      char_data  <= '0;
      char_valid <= 1'b0;
    end else begin
      char_valid <= wrap;
      if (tick) shreg <= shnext;
      if (wrap) char_data <= shnext;
    end
  end

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !char_valid |-> $stable(char_data));
endmodule

// File: rtl/recovered_byte_clk.sv
module recovered_byte_clk
  import rbc_pkg::*;
#(
  parameter int CHAR_W    = 10,
  parameter int ADJ_BITS  = 2,
  parameter int DRIFT_LIM = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              bit_in,
  input  logic              early,
  input  logic              late,
  output logic [CHAR_W-1:0] char_data,
  output logic              char_valid,
  output logic              rclk
);
  adj_e pend;
  logic wrap;

  rbc_drift_tracker #(.DRIFT_LIM(DRIFT_LIM)) u_drift (
    .clk(clk), .rst(rst), .tick(bit_tick), .early(early), .late(late),
    .consume(wrap), .pend(pend)
  );

  rbc_period_ctrl #(.CHAR_W(CHAR_W), .ADJ_BITS(ADJ_BITS)) u_period (
    .clk(clk), .rst(rst), .tick(bit_tick), .pend(pend),
    .wrap(wrap), .rclk(rclk)
  );

  rbc_char_shifter #(.CHAR_W(CHAR_W)) u_shift (
    .clk(clk), .rst(rst), .tick(bit_tick), .bit_in(bit_in), .wrap(wrap),
    .char_data(char_data), .char_valid(char_valid)
  );

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    char_valid |-> $rose(rclk));

  // R7
  rclk_fall_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rclk) |-> $past(bit_tick));
endmodule

// File: tb/recovered_byte_clk_tb.sv
module recovered_byte_clk_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b0, bit_in = 1'b0, early = 1'b0, late = 1'b0;
  logic [9:0] char_data;
  logic char_valid, rclk;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [9:0] mdl = '0, last_char = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic s_valid = 1'b0, s_rclk = 1'b0, prev_rclk = 1'b0;
  logic [9:0] s_data = '0;

  always #(CLK_P/2) clk = ~clk;

  recovered_byte_clk u_dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .bit_in(bit_in),
    .early(early), .late(late), .char_data(char_data),
    .char_valid(char_valid), .rclk(rclk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_tick(input logic e, input logic l);
    @(negedge clk);
    bit_tick = 1'b1; bit_in = lfsr[0]; early = e; late = l;
    mdl  = {lfsr[0], mdl[9:1]};
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    @(negedge clk);
    bit_tick = 1'b0; early = 1'b0; late = 1'b0;
    prev_rclk = s_rclk;
    s_valid = char_valid; s_rclk = rclk; s_data = char_data;
  endtask

  // One byte period: ne early ticks, then nl late ticks, then nb ticks with both
  task automatic period(input int exp_len, input int ne, input int nl, input int nb,
                        input bit first, input string req);
    int n = 0;
    int hi = 0;
    bit done = 1'b0;
    while (!done && n < 20) begin
      logic e, l;
      n++;
      e = (n <= ne) || (n > ne + nl && n <= ne + nl + nb);
      l = (n > ne && n <= ne + nl + nb);
      do_tick(e, l);
      if (s_valid) done = 1'b1;
      else begin
        if (s_rclk) hi++;
        chk(s_data == last_char, "R8 data held", int'(s_data), int'(last_char));
      end
    end
    chk(n == exp_len, req, n, exp_len);
    chk(s_data == mdl, "R3 character bits", int'(s_data), int'(mdl));
    chk(s_rclk && !prev_rclk, "R2 strobe on rclk rise", int'({prev_rclk, s_rclk}), 1);
    if (first) chk(hi == 0, "R1 rclk low before first char", hi, 0);
    else       chk(hi == exp_len / 2 - 1, "R7 rclk high ticks", hi + 1, exp_len / 2);
    last_char = s_data;
    @(negedge clk);
    chk(char_valid == 1'b0, "R2 strobe one clock", int'(char_valid), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_tick = 1'b1;
    repeat (3) @(negedge clk);
    chk(char_valid == 1'b0, "R1 strobe in reset", int'(char_valid), 0);
    chk(rclk == 1'b0, "R1 rclk in reset", int'(rclk), 0);
    chk(char_data == '0, "R1 data in reset", int'(char_data), 0);
    rst = 1'b0; bit_tick = 1'b0;
    mdl = '0; last_char = '0; s_rclk = 1'b0; s_valid = 1'b0; s_data = '0;
  endtask

  task automatic test_reset();
    do_reset();
    period(10, 0, 0, 0, 1'b1, "R1 first period length");
  endtask

  task automatic test_nominal();
    period(10, 0, 0, 0, 1'b0, "R2 nominal length");
    period(10, 0, 0, 0, 1'b0, "R2 nominal length again");
  endtask

  task automatic test_fast();
    period(10, 2, 0, 0, 1'b0, "R4 period while drift builds");
    period(8, 0, 0, 0, 1'b0, "R5 short period");
    period(10, 0, 0, 0, 1'b0, "R5 back to nominal");
  endtask

  task automatic test_slow();
    period(10, 0, 2, 0, 1'b0, "R4 period while drift falls");
    period(12, 0, 0, 0, 1'b0, "R6 long period");
    period(10, 0, 0, 0, 1'b0, "R6 back to nominal");
  endtask

  task automatic test_cancel();
    period(10, 1, 1, 2, 1'b0, "R4 mixed events");
    period(10, 0, 0, 0, 1'b0, "R4 no adjust after cancel");
    period(10, 0, 0, 0, 1'b0, "R4 still nominal");
  endtask

  task automatic test_single_pend();
    period(10, 4, 0, 0, 1'b0, "R9 four early events");
    period(8, 0, 0, 0, 1'b0, "R9 one short period");
    period(10, 1, 0, 0, 1'b0, "R9 only one adjust taken");
    period(8, 0, 0, 0, 1'b0, "R9 held drift of one completes");
    period(10, 0, 0, 0, 1'b0, "R9 nominal after");
  endtask

  task automatic test_idle();
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      early = 1'b1; bit_in = ~bit_in;
      @(negedge clk);
      chk(char_valid == 1'b0, "R10 no strobe while idle", int'(char_valid), 0);
      chk(rclk == s_rclk, "R10 rclk held while idle", int'(rclk), int'(s_rclk));
      chk(char_data == last_char, "R10 data held while idle", int'(char_data), int'(last_char));
    end
    early = 1'b0;
    period(10, 0, 0, 0, 1'b0, "R10 idle early ignored");
    period(10, 0, 0, 0, 1'b0, "R10 still nominal");
  endtask

  task automatic test_mid_reset();
    period(10, 2, 0, 0, 1'b0, "R1 schedule before reset");
    do_reset();
    period(10, 0, 0, 0, 1'b1, "R1 adjust cleared by reset");
    period(10, 1, 0, 0, 1'b0, "R1 drift cleared by reset");
    period(10, 0, 0, 0, 1'b0, "R1 single early no adjust");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    test_reset();
    test_nominal();
    test_fast();
    test_slow();
    test_cancel();
    test_single_pend();
    test_idle();
    test_mid_reset();
    finish_run();
  end

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end
endmodule